// File: doc/BRIEF.md
# Serial PCM Receive Port with Bit-Steal Frames

This block takes in one companded sample per frame from a serial line. The line carries a bit clock, a frame-sync level and a data line, and the block samples all three with its own system clock. A frame begins on the first falling edge of the bit clock at which the sync is seen high, after a falling edge at which it was seen low. The block shifts in the data bits at falling edges, most significant bit first. It moves the finished word to a parallel output on the falling edge that follows the last data bit. That output edge is why a burst bit clock must give one pulse more than the word width. The block does no expansion, no filtering and no conversion.

Two watch circuits run beside the receiver. The first flags a receive power-down when the sync line stops moving. The second flags a whole-port power-down when the shared power-down/select input stays low for longer than a set number of milliseconds. Time is counted in system-clock cycles, and a parameter gives the number of cycles per millisecond. The same select input is used to arm an optional bit-steal mode through a timed sequence. Once the mode is armed, the select level at each frame start chooses whether that frame carries a short word. In a short word the least significant bit is replaced by a fixed fill value, and a flag is raised with the output word.

Top module: `pcmrx_top`

## Requirements
- R1: All inputs are sampled on rising edges of `clk`. A bit-clock falling edge is a sample where `bclk` is 0 and the previous sample was 1. A frame starts at a falling edge where `fsync` is 1, provided `fsync` was 0 at the previous falling edge. The `sdin` bit taken at the start edge is the word's most significant bit. The following falling edges supply the lower bits in order.
- R2: The word is moved to `rx_word` on the first falling edge after the last data bit (the ninth edge for W=8). At the same time `rx_valid` is high for exactly one `clk` cycle. `rx_word` and `rx_short` keep their values until the next transfer.
- R3: A frame whose clock stops after only W edges produces no output. Its bits are dropped when the next frame starts, because a new start always restarts assembly. Falling edges after the transfer edge are ignored until the next frame start.
- R4: `rx_pd` is high once `fsync` has held the same level for more than SYNC_LOSS_CLKS consecutive samples, whether high or low. It is high from reset. It clears on the first sample that shows a change of `fsync`.
- R5: `dev_pd` is high once `pdsel` has been low for more than PD_MS*CLK_PER_MS consecutive samples. It clears on the first high sample. While it is high, any partial frame is dropped, no transfer occurs, and bit-steal arming returns to idle.
- R6: Bit-steal arming (`steal_on` going to 1) needs these steps in order. First, `pdsel` is held high for at least HOLD_MS*CLK_PER_MS samples. Second, while it stays high, `rx_pd` is reached with `fsync` stuck low. Third, `pdsel` goes low and then back high. Fourth, a frame start occurs. The frame that completes the arming is still a full-width frame.
- R7: While armed, `pdsel` is sampled at each frame-start edge. If it was 1, the transferred word has bit 0 replaced by FILL_BIT (1) and `rx_short` is 1. If it was 0, the full word is output and `rx_short` is 0.
- R8: Arming is rejected if the high hold is shorter than HOLD_MS ms, if `pdsel` drops before the sync stop, or if a frame starts before the pulse is complete. In any of these cases `steal_on` stays 0 and `pdsel` high at a frame start gives a full word.
- R9: After reset, `rx_word`=0, `rx_valid`=0, `rx_short`=0, `dev_pd`=0, `steal_on`=0 and `rx_pd`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock, continuous or burst |
| fsync | input | 1 | Frame-sync level marking the first bit |
| sdin | input | 1 | Serial data, most significant bit first |
| pdsel | input | 1 | Shared power-down (low) and short-frame select (high) input |
| rx_word | output | W | Last completed received word |
| rx_valid | output | 1 | One-cycle strobe on each transfer |
| rx_short | output | 1 | The last transferred word was a short (7-bit) frame |
| rx_pd | output | 1 | Receive power-down: sync has stopped toggling |
| dev_pd | output | 1 | Whole-port power-down: select held low too long |
| steal_on | output | 1 | Bit-steal mode is armed |

## Verification
The hardest state to reach is the armed bit-steal mode. Getting there takes a long high hold on the select input, then a sync stop long enough to trip receive power-down, then a short select pulse that must not trip port power-down, and finally a frame restart, all in that order. The bench sets the millisecond to 20 cycles so that the hold and sync-loss windows stay short. It runs enough back-to-back frames to cover the hold, stops the sync, pulses the select and restarts the frames. Before that, it replays the same sequence with a hold that is too short, so that rejection is also exercised. A per-cycle behavioural model tracks the arming state and is compared on every clock.

// File: rtl/pcmrx_pkg.sv
`timescale 1ns/1ps
package pcmrx_pkg;

    typedef enum logic [2:0] {
        ARM_IDLE,
        ARM_HELD,
        ARM_STOP,
        ARM_PULSE,
        ARM_WAIT,
        ARM_ON
    } arm_state_e;

endpackage

// File: rtl/pcmrx_runlen.sv
`timescale 1ns/1ps
// Saturating run-length counter: counts consecutive samples without restart.
module pcmrx_runlen #(
    parameter int unsigned LIMIT      = 4,
    parameter bit          STRICT     = 1'b1,  // 1: hit when run > LIMIT, 0: run >= LIMIT
    parameter bit          START_FULL = 1'b0   // reset to a saturated run
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic hit
);
    localparam int unsigned CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] TOP = CW'(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_s;

    run_s run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (restart) begin
            run_d.cnt = '0;
        end else if (run_q.cnt != TOP) begin
            run_d.cnt = run_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q.cnt <= START_FULL ? TOP : '0;
        end else begin
            run_q <= run_d;
        end
    end

    generate
        if (STRICT) begin : g_strict
            assign hit = (run_q.cnt > LIM);
        end else begin : g_reach
            assign hit = (run_q.cnt >= LIM);
        end
    endgenerate

endmodule

// File: rtl/pcmrx_deser.sv
`timescale 1ns/1ps
// Frame detection, bit assembly and word transfer.
module pcmrx_deser #(
    parameter int unsigned W        = 8,
    parameter bit          FILL_BIT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk,
    input  logic         fsync,
    input  logic         sdin,
    input  logic         sel,
    input  logic         block,
    input  logic         armed,
    output logic         frame_start,
    output logic [W-1:0] word,
    output logic         valid,
    output logic         short_frame
);
    localparam int unsigned BCW = $clog2(W + 1);
    localparam logic [BCW-1:0] LAST = BCW'(W);

    typedef struct packed {
        logic [BCW-1:0] cnt;
        logic [W-1:0]   sh;
        logic           fs_prev;
        logic           sclk_prev;
        logic           steal;
        logic [W-1:0]   word;
        logic           shrt;
        logic           vld;
    } deser_s;

    deser_s st_d, st_q;
    logic   fall;

    assign fall        = st_q.sclk_prev & ~bclk;
    assign frame_start = fall & fsync & ~st_q.fs_prev;

    always_comb begin
        st_d           = st_q;
        st_d.vld       = 1'b0;
        st_d.sclk_prev = bclk;
        if (fall) begin
            st_d.fs_prev = fsync;
        end
        if (block) begin
            st_d.cnt = '0;
        end else if (frame_start) begin
            st_d.sh    = {{(W-1){1'b0}}, sdin};
            st_d.cnt   = BCW'(1);
            st_d.steal = armed & sel;
        end else if (fall && (st_q.cnt != '0)) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.vld  = 1'b1;
                st_d.shrt = st_q.steal;
                st_d.word = st_q.steal ? {st_q.sh[W-1:1], FILL_BIT} : st_q.sh;
            end else begin
                st_d.sh  = {st_q.sh[W-2:0], sdin};
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word        = st_q.word;
    assign valid       = st_q.vld;
    assign short_frame = st_q.shrt;

endmodule

// File: rtl/pcmrx_arm.sv
`timescale 1ns/1ps
// Bit-steal arming sequencer.
module pcmrx_arm
    import pcmrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic fsync,
    input  logic hold_ok,
    input  logic rx_down,
    input  logic dev_down,
    input  logic frame_start,
    output logic armed
);
    arm_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE:  if (hold_ok) state_d = ARM_HELD;
            ARM_HELD: begin
                if (!sel)                    state_d = ARM_IDLE;
                else if (rx_down && !fsync)  state_d = ARM_STOP;
            end
            ARM_STOP: begin
                if (frame_start)  state_d = ARM_IDLE;
                else if (!sel)    state_d = ARM_PULSE;
            end
            ARM_PULSE: begin
                if (frame_start)  state_d = ARM_IDLE;
                else if (sel)     state_d = ARM_WAIT;
            end
            ARM_WAIT:  if (frame_start) state_d = ARM_ON;
            ARM_ON:    state_d = ARM_ON;
            default:   state_d = ARM_IDLE;
        endcase
        if (dev_down) begin
            state_d = ARM_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign armed = (state_q == ARM_ON);

endmodule

// File: rtl/pcmrx_top.sv
`timescale 1ns/1ps
module pcmrx_top #(
    parameter int unsigned W              = 8,
    parameter int unsigned CLK_PER_MS     = 100000,
    parameter int unsigned PD_MS          = 1,
    parameter int unsigned HOLD_MS        = 10,
    parameter int unsigned SYNC_LOSS_CLKS = 100000,
    parameter bit          FILL_BIT       = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk,
    input  logic         fsync,
    input  logic         sdin,
    input  logic         pdsel,
    output logic [W-1:0] rx_word,
    output logic         rx_valid,
    output logic         rx_short,
    output logic         rx_pd,
    output logic         dev_pd,
    output logic         steal_on
);
    localparam int unsigned PD_LIM   = PD_MS * CLK_PER_MS;
    localparam int unsigned HOLD_LIM = HOLD_MS * CLK_PER_MS;

    logic sync_prev_d, sync_prev_q;
    logic hold_ok;
    logic frame_start;

    assign sync_prev_d = fsync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_prev_q <= 1'b0;
        end else begin
            sync_prev_q <= sync_prev_d;
        end
    end

    pcmrx_runlen #(.LIMIT(PD_LIM), .STRICT(1'b1), .START_FULL(1'b0)) u_sel_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (pdsel),
        .hit     (dev_pd)
    );

    pcmrx_runlen #(.LIMIT(HOLD_LIM), .STRICT(1'b0), .START_FULL(1'b0)) u_sel_high (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (~pdsel),
        .hit     (hold_ok)
    );

    pcmrx_runlen #(.LIMIT(SYNC_LOSS_CLKS), .STRICT(1'b1), .START_FULL(1'b1)) u_sync_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fsync ^ sync_prev_q),
        .hit     (rx_pd)
    );

    pcmrx_deser #(.W(W), .FILL_BIT(FILL_BIT)) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk        (bclk),
        .fsync       (fsync),
        .sdin        (sdin),
        .sel         (pdsel),
        .block       (dev_pd),
        .armed       (steal_on),
        .frame_start (frame_start),
        .word        (rx_word),
        .valid       (rx_valid),
        .short_frame (rx_short)
    );

    pcmrx_arm u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (pdsel),
        .fsync       (fsync),
        .hold_ok     (hold_ok),
        .rx_down     (rx_pd),
        .dev_down    (dev_pd),
        .frame_start (frame_start),
        .armed       (steal_on)
    );

endmodule

// File: rtl/pcmrx_checker.sv
`timescale 1ns/1ps
module pcmrx_checker #(
    parameter int unsigned W        = 8,
    parameter bit          FILL_BIT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] rx_word,
    input logic         rx_valid,
    input logic         rx_short,
    input logic         dev_pd,
    input logic         steal_on
);
    p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_word_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_word));

    p_block_when_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_pd |=> !rx_valid);

    p_disarm_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(steal_on) |-> $past(dev_pd));

    p_fill_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_short) |-> (rx_word[0] == FILL_BIT));

    p_short_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_short) |-> steal_on);

endmodule

bind pcmrx_top pcmrx_checker #(.W(W), .FILL_BIT(FILL_BIT)) u_chk (.*);

// File: tb/pcmrx_top_test.sv
`timescale 1ns/1ps
module pcmrx_top_test;
    localparam int W        = 8;
    localparam int CPM      = 20;
    localparam int PD_LIM   = 1 * CPM;
    localparam int HOLD_LIM = 10 * CPM;
    localparam int SYNC_LIM = 60;

    localparam int A_IDLE = 0, A_HELD = 1, A_STOP = 2, A_PULSE = 3, A_WAIT = 4, A_ON = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bclk = 1'b0, fsync = 1'b0, sdin = 1'b0, pdsel = 1'b1;
    logic [W-1:0] rx_word;
    logic rx_valid, rx_short, rx_pd, dev_pd, steal_on;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #5 clk = ~clk;

    pcmrx_top #(.W(W), .CLK_PER_MS(CPM), .PD_MS(1), .HOLD_MS(10),
                .SYNC_LOSS_CLKS(SYNC_LIM), .FILL_BIT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdin(sdin),
        .pdsel(pdsel), .rx_word(rx_word), .rx_valid(rx_valid), .rx_short(rx_short),
        .rx_pd(rx_pd), .dev_pd(dev_pd), .steal_on(steal_on));

    // behavioural reference state
    int m_low, m_high, m_srun, m_cnt, m_arm;
    int m_sh, m_word;
    bit m_sprev, m_cprev, m_fsprev, m_steal, m_valid, m_short;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_low = 0; m_high = 0; m_srun = SYNC_LIM + 1; m_cnt = 0; m_arm = A_IDLE;
            m_sh = 0; m_word = 0; m_sprev = 0; m_cprev = 0; m_fsprev = 0;
            m_steal = 0; m_valid = 0; m_short = 0;
        end else begin
            bit old_dev, old_rx, old_hold, fall, fs;
            old_dev  = (m_low > PD_LIM);
            old_rx   = (m_srun > SYNC_LIM);
            old_hold = (m_high >= HOLD_LIM);
            fall = m_cprev && !bclk;
            fs   = fall && fsync && !m_fsprev;
            case (m_arm)
                A_IDLE:  if (old_hold) m_arm = A_HELD;
                A_HELD:  if (!pdsel) m_arm = A_IDLE; else if (old_rx && !fsync) m_arm = A_STOP;
                A_STOP:  if (fs) m_arm = A_IDLE; else if (!pdsel) m_arm = A_PULSE;
                A_PULSE: if (fs) m_arm = A_IDLE; else if (pdsel) m_arm = A_WAIT;
                A_WAIT:  if (fs) m_arm = A_ON;
                default: ;
            endcase
            m_valid = 0;
            if (old_dev) m_cnt = 0;
            else if (fs) begin
                m_sh = sdin; m_cnt = 1; m_steal = (m_arm_prev_on(old_dev)) && pdsel;
            end else if (fall && m_cnt != 0) begin
                if (m_cnt == W) begin
                    m_cnt = 0; m_valid = 1; m_short = m_steal;
                    m_word = m_steal ? ((m_sh & 'hFE) | 1) : m_sh;
                end else begin
                    m_sh = ((m_sh << 1) | sdin) & 'hFF; m_cnt++;
                end
            end
            if (old_dev) m_arm = A_IDLE;
            if (fall) m_fsprev = fsync;
            m_low  = pdsel ? 0 : ((m_low < PD_LIM + 1) ? m_low + 1 : m_low);
            m_high = !pdsel ? 0 : ((m_high < HOLD_LIM) ? m_high + 1 : m_high);
            m_srun = (fsync != m_sprev) ? 0 : ((m_srun < SYNC_LIM + 1) ? m_srun + 1 : m_srun);
            m_sprev = fsync;
            m_cprev = bclk;
            m_armed_q = (m_arm == A_ON);
        end
    end

    // armed flag as seen before this edge's update
    bit m_armed_q = 0;
    function automatic bit m_arm_prev_on(input bit dummy);
        return m_armed_q && !dummy;
    endfunction

    // per-cycle comparison, away from the rising edge
    int got_n = 0;
    int got_word = 0;
    bit got_short = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            chk("R2 rx_valid", rx_valid, m_valid);
            chk("R1 rx_word", rx_word, m_word);
            chk("R7 rx_short", rx_short, m_short);
            chk("R4 rx_pd", rx_pd, (m_srun > SYNC_LIM));
            chk("R5 dev_pd", dev_pd, (m_low > PD_LIM));
            chk("R6 steal_on", steal_on, (m_arm == A_ON));
            if (rx_valid) begin
                got_n++; got_word = rx_word; got_short = rx_short;
            end
            if (cyc == 150000) begin
                n_bad++;
                $display("FAIL watchdog (all R) actual=%0d expected<%0d", cyc, 150000);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] v, input int np, input bit sel0, input bit selr);
        for (int i = 0; i < np; i++) begin
            @(negedge clk);
            bclk = 1'b1;
            sdin = (i < 8) ? v[7-i] : i[0];
            fsync = (i == 0);
            pdsel = (i == 0) ? sel0 : selr;
            @(negedge clk);
            @(negedge clk);
            bclk = 1'b0;
            @(negedge clk);
        end
        fsync = 1'b0;
        pdsel = selr;
    endtask

    initial begin
        int base;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 word", rx_word, 0);
        chk("R9 valid", rx_valid, 0);
        chk("R9 short", rx_short, 0);
        chk("R9 rx_pd", rx_pd, 1);
        chk("R9 dev_pd", dev_pd, 0);
        chk("R9 steal", steal_on, 0);

        // R1/R2: basic frames with minimum 9-pulse bursts
        send_frame(8'hA5, 9, 1, 1); idle(4);
        chk("R1 word A5", got_word, 'hA5);
        chk("R4 rx_pd cleared", rx_pd, 0);
        send_frame(8'h3C, 12, 1, 1); idle(4);   // R3 extra pulses ignored
        chk("R3 word 3C", got_word, 'h3C);
        base = got_n;
        send_frame(8'h01, 9, 1, 1); idle(4);
        chk("R2 one strobe", got_n - base, 1);
        chk("R1 word 01", got_word, 'h01);

        // R3: 8-pulse frame gives nothing; next frame restarts
        base = got_n;
        send_frame(8'hFF, 8, 1, 1); idle(4);
        chk("R3 no transfer on 8 pulses", got_n - base, 0);
        send_frame(8'h5A, 9, 1, 1); idle(4);
        chk("R3 next word 5A", got_word, 'h5A);

        // R4: sync stuck high
        fsync = 1'b1; idle(SYNC_LIM + 10);
        chk("R4 stuck high pd", rx_pd, 1);
        fsync = 1'b0; idle(3);
        chk("R4 clears on change", rx_pd, 0);
        send_frame(8'hC3, 9, 1, 1); idle(4);
        chk("R1 word C3", got_word, 'hC3);

        // R5: select held low
        pdsel = 1'b0; idle(PD_LIM + 5);
        chk("R5 dev_pd set", dev_pd, 1);
        base = got_n;
        send_frame(8'h99, 9, 0, 0); idle(4);
        chk("R5 no frame while down", got_n - base, 0);
        chk("R5 word kept", got_word, 'hC3);
        pdsel = 1'b1; idle(2);
        chk("R5 dev_pd cleared", dev_pd, 0);

        // R8: hold too short, then stop/pulse/restart
        pdsel = 1'b0; idle(5); pdsel = 1'b1;
        send_frame(8'h11, 9, 1, 1); idle(8);
        send_frame(8'h22, 9, 1, 1);
        idle(SYNC_LIM + 10);
        pdsel = 1'b0; idle(5); pdsel = 1'b1; idle(3);
        send_frame(8'h44, 9, 1, 1); idle(4);
        chk("R8 not armed", steal_on, 0);
        chk("R8 full word", got_word, 'h44);
        chk("R8 short flag", got_short, 0);

        // R6: proper arming
        for (int k = 0; k < 6; k++) begin
            send_frame(8'h10 + k, 9, 1, 1); idle(8);
        end
        idle(SYNC_LIM + 10);
        chk("R6 still unarmed at stop", steal_on, 0);
        pdsel = 1'b0; idle(5); pdsel = 1'b1; idle(3);
        send_frame(8'h66, 9, 1, 1); idle(4);
        chk("R6 armed", steal_on, 1);
        chk("R6 arming frame full", got_word, 'h66);
        chk("R6 arming frame flag", got_short, 0);

        // R7: per-frame width select
        send_frame(8'hB4, 9, 1, 1); idle(4);
        chk("R7 short word", got_word, 'hB5);
        chk("R7 short flag", got_short, 1);
        send_frame(8'hB4, 9, 0, 1); idle(4);
        chk("R7 full word", got_word, 'hB4);
        chk("R7 full flag", got_short, 0);
        send_frame(8'h7E, 9, 1, 1); idle(4);
        chk("R7 short word 7F", got_word, 'h7F);

        // R5: power-down disarms
        pdsel = 1'b0; idle(PD_LIM + 5); pdsel = 1'b1; idle(3);
        chk("R5 disarmed", steal_on, 0);
        send_frame(8'h82, 9, 1, 1); idle(4);
        chk("R5 full after disarm", got_word, 'h82);

        idle(5);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule